// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a synchronous host to an external asynchronous static RAM of 512K bytes. The host hands over one request at a time: an address, a direction flag and, for stores, a data byte. The controller then drives the memory's active-low chip-enable, write-enable and output-enable strobes, its address pins and its data pins. The data pins are brought out as a driven value, a driver-enable and a sampled input, so the pad ring can build the tri-state buffer. Every phase of a memory cycle lasts a whole number of system clocks. Each count is derived from a nanosecond minimum and the clock period, so the same code meets the memory's timing at any clock rate.

The request side follows valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must keep `req_valid` and the request fields steady until that edge. `req_ready` is high only while the controller is idle, and that is the only back-pressure. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse, and the host must accept it. Stores are timed by the write-enable strobe, with output-enable held high. The address only moves while chip-enable and write-enable are both released. After a load, the controller waits for the memory's outputs to reach high impedance before it drives the data pins again.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is 0 in the following cycle. Changes to the request fields after that edge do not affect the operation.
- R3: `mem_addr` changes only between two cycles in which both `mem_ce_n` and `mem_we_n` are 1.
- R4: A store holds `mem_ce_n` and `mem_we_n` low together for at least ceil(50 ns / clock period) cycles, with `mem_oe_n` high for the whole time.
- R5: During a store, `mem_dq_oe` is 1 whenever `mem_we_n` is 0. The store byte stays unchanged on `mem_dq_out` for at least 25 ns before the strobes rise and remains driven in the cycle after they rise.
- R6: A load holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for at least ceil(55 ns / clock period) cycles. It samples `mem_dq_in` at the end of that window and returns the byte on `rsp_rdata` alongside `rsp_valid`.
- R7: `mem_dq_oe` stays 0 for at least ceil(20 ns / clock period) cycles after the memory stops driving for a load. `mem_dq_oe` is also 0 in the cycle where `mem_oe_n` is low and in the cycle before it.
- R8: Successive falling edges of `mem_ce_n` are at least ceil(55 ns / clock period) cycles apart.
- R9: Each request produces exactly one one-cycle `rsp_valid` pulse. For a load, the pulse comes 2 + RD cycles after acceptance; for a store, 2 + WP + REC cycles after acceptance. RD, WP and REC are the phase lengths in cycles.
- R10: A load returns the byte most recently stored at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Load result, valid with rsp_valid |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Value for the data pins when driven |
| mem_dq_oe | output | 1 | Data pin driver enable |
| mem_dq_in | input | 8 | Sampled data pins |

## Verification
The bench surrounds the controller with a behavioural memory that returns the inverted byte until both access times have run out. A load window cut short by even one cycle therefore reads back wrong data. The memory model also records any address movement under an active strobe, any write-enable with output-enable low, any store overlap or data window too short, any driver contention during the high-impedance turnaround, and any cycles that start too close together. A controller that merged the setup cycle into the strobe, or released the data drivers late, would trip these checks. Stores and loads sweep a full low page of addresses and a scattered set across the whole space up to the top address. Store-then-load and load-then-store pairs run back to back, and the request fields are scrambled right after acceptance. A controller that read the live host fields, or mis-sized a phase, would return bytes that differ from the arithmetic pattern.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WREC   = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_QUIET = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  // Whole clock cycles that cover a nanosecond minimum, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Strobe levels that belong to each sequencer state.
  function automatic pin_ctl_t decode_pins(input seq_state_t s);
    pin_ctl_t p;
    p = PINS_QUIET;
    case (s)
      ST_WPULSE: begin
        p.ce_n  = 1'b0;
        p.we_n  = 1'b0;
        p.dq_oe = 1'b1;
      end
      ST_WREC: p.dq_oe = 1'b1;
      ST_RACC: begin
        p.ce_n = 1'b0;
        p.oe_n = 1'b0;
      end
      default: p = PINS_QUIET;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int WP_CYC   = 13,
  parameter int REC_CYC  = 1,
  parameter int RD_CYC   = 14,
  parameter int TURN_CYC = 5,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output seq_state_t        state_d,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              capture,
  output logic              wr_done
);

  seq_state_t       state_q;
  logic             write_q;
  logic             last;
  logic             load;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_SETUP;
      ST_SETUP:  state_d = write_q ? ST_WPULSE : ST_RACC;
      ST_WPULSE: if (last) state_d = ST_WREC;
      ST_WREC:   if (last) state_d = ST_IDLE;
      ST_RACC:   if (last) state_d = ST_RTURN;
      ST_RTURN:  if (last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Each new phase loads its length minus one; the timer flags the last cycle.
  always_comb begin
    load = (state_d != state_q);
    case (state_d)
      ST_WPULSE: load_val = CNT_W'(WP_CYC - 1);
      ST_WREC:   load_val = CNT_W'(REC_CYC - 1);
      ST_RACC:   load_val = CNT_W'(RD_CYC - 1);
      ST_RTURN:  load_val = CNT_W'(TURN_CYC - 1);
      default:   load_val = '0;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      // Fields are copied only at acceptance; strobes are all high then.
      if (state_q == ST_IDLE && req_valid) begin
        write_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign capture   = (state_q == ST_RACC) && last;
  assign wr_done   = (state_q == ST_WREC) && last;

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_d,
  input  logic              capture,
  input  logic              wr_done,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  pin_ctl_t pins_q;

  // Strobes come straight from flops so the memory never sees a decode glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q    <= PINS_QUIET;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      pins_q    <= decode_pins(state_d);
      rsp_valid <= capture | wr_done;
      if (capture) rsp_rdata <= dq_in;
    end
  end

  assign ce_n  = pins_q.ce_n;
  assign we_n  = pins_q.we_n;
  assign oe_n  = pins_q.oe_n;
  assign dq_oe = pins_q.dq_oe;

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 4,
  parameter int T_CYC_NS  = 55,
  parameter int T_WP_NS   = 45,
  parameter int T_AW_NS   = 50,
  parameter int T_CW_NS   = 50,
  parameter int T_DW_NS   = 25,
  parameter int T_AA_NS   = 55,
  parameter int T_ACE_NS  = 55,
  parameter int T_OE_NS   = 30,
  parameter int T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int WC_CYC   = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int WP_CYC   = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                 max2(ns_to_cyc(T_CW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int RD_CYC   = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_ACE_NS, CLK_NS)),
                                 max2(ns_to_cyc(T_OE_NS, CLK_NS), WC_CYC));
  // Setup and idle each add one cycle to the start-to-start span of a store.
  localparam int REC_CYC  = max2(1, WC_CYC - WP_CYC - 2);
  localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC  = max2(max2(WP_CYC, REC_CYC), max2(RD_CYC, TURN_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  seq_state_t state_d;
  logic       capture;
  logic       wr_done;

  sram_seq_fsm #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WP_CYC   (WP_CYC),
    .REC_CYC  (REC_CYC),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .state_d   (state_d),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .capture   (capture),
    .wr_done   (wr_done)
  );

  sram_pin_regs #(.DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .capture   (capture),
    .wr_done   (wr_done),
    .dq_in     (mem_dq_in),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int WR_CYC = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  logic [15:0] ov_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_cnt <= '0;
    else if (!mem_ce_n && !mem_we_n) ov_cnt <= (ov_cnt == 16'hFFFF) ? ov_cnt : ov_cnt + 1'b1;
    else ov_cnt <= '0;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r3_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_addr) |-> (mem_ce_n && mem_we_n && $past(mem_ce_n) && $past(mem_we_n)));

  a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && $past(!mem_we_n)) |-> (ov_cnt >= 16'(WR_CYC)));

  a_r5_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);

  a_r6_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  a_r7_driver_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && $past(!mem_dq_oe)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind sram_async_ctl sram_async_ctl_chk #(
  .ADDR_W (ADDR_W),
  .WR_CYC (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_async_ctl.sv
`timescale 1ns/1ps
module tb_sram_async_ctl;

  localparam int CLK_NS = 4;
  localparam int AW = 19;
  localparam int DW = 8;
  // Expected phase lengths, worked out from the requirement arithmetic.
  localparam int E_WP  = (50 + CLK_NS - 1) / CLK_NS;
  localparam int E_RD  = (55 + CLK_NS - 1) / CLK_NS;
  localparam int E_WC  = (55 + CLK_NS - 1) / CLK_NS;
  localparam int E_REC = (E_WC - E_WP - 2 > 1) ? E_WC - E_WP - 2 : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  always #2 clk = ~clk;

  sram_async_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory, sampled once per cycle ----------------
  logic [DW-1:0] model_mem [int];
  logic [DW-1:0] dq_in_r = '0;
  assign mem_dq_in = dq_in_r;

  int ce_run = 0, oe_run = 0, ov = 0, dstab = 0, gap = 0, hz = 1000;
  bit seen_fall = 1'b0;
  logic p_ce = 1'b1, p_we = 1'b1, p_ovl = 1'b0;
  logic [AW-1:0] p_addr = '0, wa = '0;
  logic [DW-1:0] wd_last = '0;

  always @(negedge clk) begin
    logic ovl, mdrv, rd_ok;
    logic [DW-1:0] b;
    if (rst_n) begin
      if (mem_addr != p_addr && !(p_ce && p_we && mem_ce_n && mem_we_n))
        chk(0, "R3 address moved under strobe", int'(mem_addr), int'(p_addr));
      if (!mem_we_n && !mem_oe_n)
        chk(0, "R4 write with output enable low", int'(mem_oe_n), 1);
      if (!mem_ce_n && p_ce) begin
        if (seen_fall && gap * CLK_NS < 55) chk(0, "R8 start-to-start", gap, E_WC);
        seen_fall = 1'b1;
        gap = 1;
      end else if (gap < 1000) gap++;
      ovl = !mem_ce_n && !mem_we_n;
      if (ovl) begin
        ov++;
        if (mem_dq_oe && ov > 1 && mem_dq_out == wd_last) dstab++;
        else dstab = mem_dq_oe ? 1 : 0;
        wd_last = mem_dq_out;
        wa = mem_addr;
      end else if (p_ovl) begin
        chk(ov * CLK_NS >= 50, "R4 write overlap length", ov, E_WP);
        chk(dstab * CLK_NS >= 25, "R5 data stable before write end", dstab, E_WP);
        chk(mem_dq_oe, "R5 data held after write end", int'(mem_dq_oe), 1);
        model_mem[int'(wa)] = wd_last;
        ov = 0;
        dstab = 0;
      end
      mdrv = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && (mdrv || hz * CLK_NS < 20))
        chk(0, "R7 driver contention during turnaround", hz, 5);
      if (mdrv) hz = 0;
      else if (hz < 1000) hz++;
      ce_run = !mem_ce_n ? ce_run + 1 : 0;
      oe_run = !mem_oe_n ? oe_run + 1 : 0;
      rd_ok = (ce_run * CLK_NS >= 55) && (oe_run * CLK_NS >= 30) && mem_we_n;
      b = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
      dq_in_r = rd_ok ? b : ~b;
      p_ce = mem_ce_n;
      p_we = mem_we_n;
      p_ovl = ovl;
      p_addr = mem_addr;
    end
  end

  // ---------------- host side ----------------
  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [7:0] salt);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b10101} ^ salt;
  endfunction

  task automatic host_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] q);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle strobes quiet",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = ~wr;
    req_addr  = ~a;
    req_wdata = ~d;
    chk(!req_ready, "R2 ready low after acceptance", int'(req_ready), 0);
    n = 1;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == (wr ? 2 + E_WP + E_REC : 2 + E_RD), "R9 completion latency", n,
        wr ? 2 + E_WP + E_REC : 2 + E_RD);
    q = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R9 completion is one cycle", int'(rsp_valid), 0);
  endtask

  initial begin
    logic [DW-1:0] q;
    logic [AW-1:0] a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
        "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid},
        6'b111010);

    // Full low page: stores then loads (R10, R6).
    for (int i = 0; i < 256; i++) host_op(1'b1, AW'(i), pat(AW'(i), 8'h00), q);
    for (int i = 0; i < 256; i++) begin
      host_op(1'b0, AW'(i), 8'h00, q);
      chk(q == pat(AW'(i), 8'h00), "R10 page readback", q, pat(AW'(i), 8'h00));
    end

    // Scattered addresses: store, load back, then a load before the next store.
    for (int i = 0; i < 64; i++) begin
      a = (i == 63) ? {AW{1'b1}} : (AW'(i * 40503 + 12345) | AW'(19'h01000));
      host_op(1'b1, a, pat(a, 8'h5A), q);
      host_op(1'b0, a, 8'h00, q);
      chk(q == pat(a, 8'h5A), "R6 R10 scattered readback", q, pat(a, 8'h5A));
      host_op(1'b0, AW'(i * 4), 8'h00, q);
      chk(q == pat(AW'(i * 4), 8'h00), "R7 load then store page check", q,
          pat(AW'(i * 4), 8'h00));
    end

    // Overwrite one location and confirm only the new byte survives.
    host_op(1'b1, AW'(7), 8'hC3, q);
    host_op(1'b0, AW'(7), 8'h00, q);
    chk(q == 8'hC3, "R10 overwrite", q, 8'hC3);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule